// File: doc/BRIEF.md
# Three-Channel Tone Noise Mixer

This block produces the digital level for three sound channels. Each channel has a square-wave tone source with its own 12-bit period. All three channels share one pseudo-random noise source. Per channel, the tone and the noise are gated together under individual disable bits. The gated result either passes a level to the output or forces silence.

The level that is passed is chosen per channel. It is either a fixed 4-bit value from the channel's amplitude register or the 4-bit level supplied by an external envelope source. All register values arrive as plain inputs, so the block holds no register file of its own. The outputs are three registered 4-bit levels, ready for a digital-to-analog stage. A common prescaler divides the clock before every period counter.

Top module: `tone_noise_mixer`

## Requirements
- R1: While rst_n is low at a clock edge, all three levels are 0.
- R2: A channel's tone period is {coarse[3:0], fine[7:0]} (12 bits); coarse bits 7..4 are ignored. The tone output toggles once every period prescaled ticks, so the gated level repeats every 2 × period × PRESCALE clocks.
- R3: The three channels run independently, each from its own fine/coarse pair and amplitude register.
- R4: mix_reg bits 0, 1, 2 disable the tone of channels A, B, C, and bits 3, 4, 5 disable their noise (1 = disabled). Bits 7..6 are ignored.
- R5: A disabled source counts as logic 1. The channel gate is the AND of the tone term and the noise term, so with both disabled the selected level is output steadily.
- R6: In an amplitude register, bits 3..0 are a fixed level and bit 4 = 1 selects env_level instead. Bits 7..5 are ignored.
- R7: When the channel gate is 0, the channel level is 0.
- R8: A tone or noise period of 0 behaves the same as a period of 1.
- R9: The noise period is noise_reg[4:0] (bits 7..5 ignored). Each noise period, a 17-bit shift register that resets to 1 shifts right and takes bit0 XOR bit3 into bit 16. The noise source is bit 0 after the shift.
- R10: Period counters advance only on a prescaler tick, which occurs once every PRESCALE clocks. The first tick comes on the PRESCALE-th edge after reset is released.
- R11: A channel level is registered, so when the envelope is selected and the gate is open it shows env_level one clock after that input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_fine_a | input | 8 | Channel A tone period, low byte |
| tone_coarse_a | input | 8 | Channel A tone period, upper nibble in bits 3..0 |
| tone_fine_b | input | 8 | Channel B tone period, low byte |
| tone_coarse_b | input | 8 | Channel B tone period, upper nibble in bits 3..0 |
| tone_fine_c | input | 8 | Channel C tone period, low byte |
| tone_coarse_c | input | 8 | Channel C tone period, upper nibble in bits 3..0 |
| noise_reg | input | 8 | Noise period in bits 4..0 |
| mix_reg | input | 8 | Tone disables (bits 2..0) and noise disables (bits 5..3) |
| amp_reg_a | input | 8 | Channel A fixed level (3..0) and envelope select (4) |
| amp_reg_b | input | 8 | Channel B fixed level (3..0) and envelope select (4) |
| amp_reg_c | input | 8 | Channel C fixed level (3..0) and envelope select (4) |
| env_level | input | 4 | Envelope level from the external generator |
| level_a | output | 4 | Channel A output level |
| level_b | output | 4 | Channel B output level |
| level_c | output | 4 | Channel C output level |

## Verification
The bench builds the block with PRESCALE = 2 and leaves the other parameters at their defaults. With PRESCALE = 2, a 261-tick tone period completes in about a thousand clocks, and the noise register steps every second clock. The bench can therefore measure full tone cycles and follow forty noise steps against its own shift-register model in a short run. The small divider also leaves the tick spacing and the period-0 case easy to observe, while the 12-bit and 17-bit widths remain those of the default build.

// File: rtl/tnm_pkg.sv
// Shared constants and types for the three-channel tone/noise mixer.
// Assumes three channels with 4-bit output levels.
package tnm_pkg;
    localparam int NCH          = 3;
    localparam int LVL_W        = 4;
    localparam int REG_W        = 8;
    localparam int MODE_BIT     = 4;   // amplitude register: envelope select
    localparam int NOISE_OFF_LO = 3;   // mix register: first noise disable bit
    typedef logic [LVL_W-1:0] level_t;
endpackage

// File: rtl/tnm_prescaler.sv
// Clock prescaler: raises tick for one clock out of every DIV clocks.
// Assumes DIV >= 1; DIV == 1 gives a tick on every clock.
module tnm_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            logic unused_ports;
            assign unused_ports = clk ^ rst_n;
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            // Count clocks modulo DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)           cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end

            assign tick = (cnt == LAST);

            // Ticks are never back to back when dividing.
            assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tnm_period_div.sv
// Programmable period divider: counts prescaler ticks and pulses expire
// on the tick that completes a period. A period of 0 is treated as 1.
// A counter past a newly lowered period wraps on its next tick.
module tnm_period_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic [W-1:0] eff;
    logic [W:0]   nxt;

    assign eff    = (period == '0) ? W'(1) : period;
    assign nxt    = {1'b0, cnt} + (W+1)'(1);
    assign expire = tick && (nxt >= {1'b0, eff});

    // Advance on each tick, wrapping when the period completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (expire) cnt <= '0;
        else if (tick)   cnt <= nxt[W-1:0];
    end

    // The counter only moves on a tick.
    assert_cnt_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/tnm_tone.sv
// Square-wave tone source: toggles its output each time its period divider
// expires. Output starts at 0 after reset.
module tnm_tone #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic         tone
);
    logic expire;

    tnm_period_div #(.W(W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .period (period),
        .expire (expire)
    );

    // Toggle the square wave at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      tone <= 1'b0;
        else if (expire) tone <= ~tone;
    end

    assert_tone_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tone));
endmodule

// File: rtl/tnm_noise.sv
// Pseudo-random noise source: a right-shifting LFSR stepped once per noise
// period. Feedback is bit0 XOR bit TAP, entering at the top bit.
// Resets to 1 so the register never locks at zero.
module tnm_noise #(
    parameter int PW  = 5,
    parameter int LW  = 17,
    parameter int TAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [PW-1:0] period,
    output logic          noise
);
    logic          expire;
    logic [LW-1:0] lfsr;
    logic          fb;

    tnm_period_div #(.W(PW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .period (period),
        .expire (expire)
    );

    assign fb    = lfsr[0] ^ lfsr[TAP];
    assign noise = lfsr[0];

    // Step the shift register at each noise period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      lfsr <= LW'(1);
        else if (expire) lfsr <= {fb, lfsr[LW-1:1]};
    end

    assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);
    assert_noise_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lfsr));
endmodule

// File: rtl/tnm_chan_out.sv
// Per-channel gate and amplitude select. A disabled source counts as 1.
// The gate is the AND of the tone and noise terms. The registered level is
// either the fixed level or the envelope level, or 0 when the gate is closed.
module tnm_chan_out
    import tnm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tone,
    input  logic   noise,
    input  logic   tone_off,
    input  logic   noise_off,
    input  level_t fixed_level,
    input  logic   env_mode,
    input  level_t env_level,
    output level_t level
);
    logic   gate;
    level_t sel;

    assign gate = (tone | tone_off) & (noise | noise_off);
    assign sel  = env_mode ? env_level : fixed_level;

    // Register the gated level.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= gate ? sel : '0;
    end

    assert_tone_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tone_off && !tone) |=> (level == '0));
    assert_noise_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!noise_off && !noise) |=> (level == '0));
    assert_env_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_off && noise_off && env_mode) |=> (level == $past(env_level)));
    assert_fixed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_off && noise_off && !env_mode) |=> (level == $past(fixed_level)));
endmodule

// File: rtl/tone_noise_mixer.sv
// Three-channel tone/noise mixer top. One prescaler feeds three tone
// sources and one shared noise source. Each channel gates tone and noise
// under its disable bits and outputs a fixed or envelope level.
// Assumes register inputs are synchronous to clk.
module tone_noise_mixer
    import tnm_pkg::*;
#(
    parameter int PRESCALE = 16,
    parameter int TONE_W   = 12,
    parameter int NOISE_W  = 5,
    parameter int LFSR_W   = 17,
    parameter int LFSR_TAP = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tone_fine_a,
    input  logic [7:0] tone_coarse_a,
    input  logic [7:0] tone_fine_b,
    input  logic [7:0] tone_coarse_b,
    input  logic [7:0] tone_fine_c,
    input  logic [7:0] tone_coarse_c,
    input  logic [7:0] noise_reg,
    input  logic [7:0] mix_reg,
    input  logic [7:0] amp_reg_a,
    input  logic [7:0] amp_reg_b,
    input  logic [7:0] amp_reg_c,
    input  logic [3:0] env_level,
    output logic [3:0] level_a,
    output logic [3:0] level_b,
    output logic [3:0] level_c
);
    localparam int COARSE_W = TONE_W - REG_W;

    logic              tick;
    logic              noise;
    logic [REG_W-1:0]  fine   [NCH];
    logic [REG_W-1:0]  coarse [NCH];
    logic [REG_W-1:0]  amp    [NCH];
    logic [TONE_W-1:0] period [NCH];
    logic [NCH-1:0]    tone;
    level_t            lvl    [NCH];
    logic              unused_bits;

    assign fine[0]   = tone_fine_a;
    assign fine[1]   = tone_fine_b;
    assign fine[2]   = tone_fine_c;
    assign coarse[0] = tone_coarse_a;
    assign coarse[1] = tone_coarse_b;
    assign coarse[2] = tone_coarse_c;
    assign amp[0]    = amp_reg_a;
    assign amp[1]    = amp_reg_b;
    assign amp[2]    = amp_reg_c;
    assign level_a   = lvl[0];
    assign level_b   = lvl[1];
    assign level_c   = lvl[2];

    assign unused_bits = ^{tone_coarse_a[7:COARSE_W], tone_coarse_b[7:COARSE_W],
                           tone_coarse_c[7:COARSE_W], noise_reg[7:NOISE_W],
                           mix_reg[7:NOISE_OFF_LO+NCH], amp_reg_a[7:MODE_BIT+1],
                           amp_reg_b[7:MODE_BIT+1], amp_reg_c[7:MODE_BIT+1]};

    tnm_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tnm_noise #(.PW(NOISE_W), .LW(LFSR_W), .TAP(LFSR_TAP)) u_noise (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .period (noise_reg[NOISE_W-1:0]),
        .noise  (noise)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            assign period[ch] = {coarse[ch][COARSE_W-1:0], fine[ch]};

            tnm_tone #(.W(TONE_W)) u_tone (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .period (period[ch]),
                .tone   (tone[ch])
            );

            tnm_chan_out u_out (
                .clk         (clk),
                .rst_n       (rst_n),
                .tone        (tone[ch]),
                .noise       (noise),
                .tone_off    (mix_reg[ch]),
                .noise_off   (mix_reg[NOISE_OFF_LO+ch]),
                .fixed_level (amp[ch][LVL_W-1:0]),
                .env_mode    (amp[ch][MODE_BIT]),
                .env_level   (env_level),
                .level       (lvl[ch])
            );
        end
    endgenerate

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (level_a == '0 && level_b == '0 && level_c == '0));
endmodule

// File: tb/sim_tone_noise_mixer.sv
module sim_tone_noise_mixer;
    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fa = 0, ca = 0, fb = 0, cb = 0, fc = 0, cc = 0;
    logic [7:0] nreg = 0, mix = 8'hFF, aa = 0, ab = 0, ac = 0;
    logic [3:0] env = 0;
    logic [3:0] la, lb, lc;
    int cyc = 0;
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tone_noise_mixer #(.PRESCALE(P)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tone_fine_a(fa), .tone_coarse_a(ca),
        .tone_fine_b(fb), .tone_coarse_b(cb),
        .tone_fine_c(fc), .tone_coarse_c(cc),
        .noise_reg(nreg), .mix_reg(mix),
        .amp_reg_a(aa), .amp_reg_b(ab), .amp_reg_c(ac),
        .env_level(env),
        .level_a(la), .level_b(lb), .level_c(lc)
    );

    typedef struct packed {
        logic [7:0] mix, a, b, c;
        logic [3:0] env, ea, eb, ec;
    } vec_t;

    // Static gating and amplitude cases (tones and noise disabled).
    localparam vec_t VEC [6] = '{
        '{8'hFF, 8'h05, 8'h10, 8'h0F, 4'hA, 4'h5, 4'hA, 4'hF},
        '{8'h3F, 8'hE3, 8'h1F, 8'h00, 4'h6, 4'h3, 4'h6, 4'h0},
        '{8'hFF, 8'h10, 8'h12, 8'h17, 4'hC, 4'hC, 4'hC, 4'hC},
        '{8'hBF, 8'h0A, 8'h09, 8'hF1, 4'h0, 4'hA, 4'h9, 4'h0},
        '{8'h7F, 8'hAF, 8'h5E, 8'h4B, 4'h7, 4'hF, 4'h7, 4'hB},
        '{8'hFF, 8'h00, 8'h00, 8'h00, 4'hF, 4'h0, 4'h0, 4'h0}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] lv(input int ch);
        return (ch == 0) ? la : (ch == 1) ? lb : lc;
    endfunction

    // Full period of a channel, measured between its 2nd and 3rd rising levels.
    task automatic measure(input int ch, output int per);
        int   rises = 0;
        int   t_prev = 0;
        logic prev;
        logic cur;
        per  = -1;
        prev = (lv(ch) != 0);
        while (rises < 3) begin
            @(negedge clk);
            cur = (lv(ch) != 0);
            if (cur && !prev) begin
                rises++;
                if (rises == 3) per = cyc - t_prev;
                t_prev = cyc;
            end
            prev = cur;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int per;
        int miss;
        int first_act;
        int first_exp;
        logic [16:0] m;

        // R1: levels stay 0 during reset even with levels that would pass.
        mix = 8'hFF; aa = 8'h0F; ab = 8'h0F; ac = 8'h0F;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 level_a in reset", la, 0);
        chk("R1 level_b in reset", lb, 0);
        chk("R1 level_c in reset", lc, 0);
        rst_n = 1'b1;

        // R4 R5 R6: vector table walk.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mix = VEC[i].mix; aa = VEC[i].a; ab = VEC[i].b; ac = VEC[i].c; env = VEC[i].env;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R4 R5 R6 vec%0d A", i), la, VEC[i].ea);
            chk($sformatf("R4 R5 R6 vec%0d B", i), lb, VEC[i].eb);
            chk($sformatf("R4 R5 R6 vec%0d C", i), lc, VEC[i].ec);
        end

        // R11: envelope followed one clock after it changes.
        @(negedge clk);
        mix = 8'hFF; aa = 8'h10; env = 4'h3;
        @(posedge clk); @(negedge clk);
        chk("R11 env 3", la, 3);
        env = 4'hD;
        @(posedge clk); @(negedge clk);
        chk("R11 env D", la, 13);

        // R7: tone A enabled with a long period stays low, so level A is 0.
        fa = 8'hFF; ca = 8'h0F; mix = 8'hFE; aa = 8'h0F; ab = 8'h0F;
        do_reset();
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R7 closed gate mutes A", la, 0);
        chk("R5 both disabled passes B", lb, 15);

        // R2 R3 R10: three tones at once with distinct periods.
        fa = 8'h03; ca = 8'hF0;   // period 3, coarse upper nibble ignored
        fb = 8'h05; cb = 8'h01;   // period 261
        fc = 8'h00; cc = 8'h00;   // period 0
        mix = 8'hF8; aa = 8'h0F; ab = 8'h0F; ac = 8'h0F;
        do_reset();
        measure(0, per);
        chk("R2 R10 channel A period", per, 2 * 3 * P);
        measure(1, per);
        chk("R2 R3 channel B period", per, 2 * 261 * P);
        measure(2, per);
        chk("R8 channel C period 0", per, 2 * 1 * P);
        @(negedge clk);
        fc = 8'h01;
        measure(2, per);
        chk("R8 channel C period 1", per, 2 * 1 * P);

        // R9: noise only on A, noise period 1 (upper bits ignored).
        nreg = 8'hE1; mix = 8'hF7; aa = 8'h0F;
        fa = 8'h00; ca = 8'h00; fb = 8'h00; cb = 8'h00; fc = 8'h00; cc = 8'h00;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        m = 17'd1;
        miss = 0; first_act = 0; first_exp = 0;
        for (int k = 1; k <= 40; k++) begin
            repeat (P) @(posedge clk);
            @(negedge clk);
            m = {m[0] ^ m[3], m[16:1]};
            if (la != (m[0] ? 4'hF : 4'h0)) begin
                if (miss == 0) begin
                    first_act = la;
                    first_exp = m[0] ? 15 : 0;
                end
                miss++;
            end
        end
        chk("R9 noise sequence first mismatch", first_act, first_exp);
        chk("R9 noise mismatch count", miss, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule